// File: doc/BRIEF.md
# Interrupt Vector and DMA-Request Logic

This block keeps the interrupt status and interrupt mask of a serial bus controller. Single-cycle event pulses from the controller's datapath set status bits. The block drives one level interrupt line, which is high while any status bit is both set and enabled. It also drives two DMA request lines, one for receive-ready and one for transmit-ready, each gated by its own enable bit in a DMA control register.

Software reaches the block through a small register port. Register reads are combinational. Writes and read side effects take effect at the clock edge. The parameter `NEW_REV` selects how pending interrupts are acknowledged:
- With `NEW_REV = 0`, a vector register returns the code of the lowest pending enabled source and clears that source as it is read.
- With `NEW_REV = 1`, the vector register reads zero. Status bits are cleared by writing ones to them, and a self-test write forces the low six status bits to one.

Register map (`addr`): 0 mask, 1 status, 2 vector, 3 DMA control, 4 self-test (write only, reads 0). Any other address reads 0 and ignores writes.

Top module: `irq_vector_dma`

## Requirements
- R1: `irq` goes high on the clock edge after `status & mask` becomes nonzero, and low on the edge after it becomes zero.
- R2: With `NEW_REV = 0`, reading address 2 returns i+1, where i is the lowest set bit of `status & mask`. It returns 0 when no bit is pending. The read clears status bit i at the clock edge.
- R3: `drq_rx` equals status bit 3 only while DMA control bit 15 is set, and `drq_tx` equals status bit 4 only while DMA control bit 7 is set. Otherwise each is low. Both lag the register state by one edge.
- R4: A write to address 3 keeps only data bits 15 and 7, which read back in those positions. Setting bit 15 clears mask bit 3, and setting bit 7 clears mask bit 4.
- R5: A write to address 0 stores data bits 4..0 when `NEW_REV = 0` and data bits 5..0 when `NEW_REV = 1`. The other mask bits read 0.
- R6: With `NEW_REV = 1`, writing address 1 clears each status bit written with a one, and only among bits 0, 1, 2 and 5. In that revision, reading address 2 returns 0 and changes nothing. With `NEW_REV = 0`, writes to address 1 are ignored.
- R7: With `NEW_REV = 1`, a write to address 4 with data bit 11 set sets status bits 5..0. With `NEW_REV = 0`, the same write has no effect on status.
- R8: An event pulse and a clear of a different status bit in the same cycle both take effect. If they target the same bit, the event wins and the bit stays set.
- R9: After reset, mask, status, DMA control, `irq`, `drq_rx` and `drq_tx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | STAT_W | Event pulses, one per status bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the vector side effect) |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational from current state |
| irq | output | 1 | Registered interrupt line |
| drq_rx | output | 1 | Registered receive DMA request |
| drq_tx | output | 1 | Registered transmit DMA request |

## Verification
Read data is due within the same cycle as the read strobe. The bench samples it a quarter period after the falling edge on which it drives the strobe, before the capturing rising edge.

Status, mask and DMA control change on the rising edge that ends a write, read or event cycle. The line outputs `irq`, `drq_rx` and `drq_tx` follow one rising edge later. The bench therefore waits one extra idle cycle after a stimulus before it samples those lines.

State changes are checked through a later register read rather than on the same edge.

// File: rtl/irq_vector_dma.sv
module irq_vector_dma #(
  parameter bit NEW_REV = 1'b0,
  parameter int STAT_W  = 6,
  parameter int DW      = 16,
  parameter int AW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_set,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq,
  output logic              drq_rx,
  output logic              drq_tx
);
  localparam int IW = (STAT_W > 1) ? $clog2(STAT_W) : 1;
  localparam int MASK_BITS = NEW_REV ? 6 : 5;
  localparam logic [STAT_W-1:0] MASK_KEEP = STAT_W'((1 << MASK_BITS) - 1);
  localparam logic [STAT_W-1:0] W1C_KEEP  = STAT_W'(6'h27);
  localparam logic [STAT_W-1:0] FORCE_SET = STAT_W'(6'h3f);
  localparam int RX_BIT = 3, TX_BIT = 4;
  localparam int DMA_RX_EN = 15, DMA_TX_EN = 7, TEST_FORCE = 11;
  localparam logic [AW-1:0] A_MASK = AW'(0), A_STAT = AW'(1), A_VEC = AW'(2),
                            A_DMA = AW'(3), A_TEST = AW'(4);

  logic [STAT_W-1:0] status, mask, pend, clr_vec, clr_w1c, force_set, status_nx;
  logic              dma_rx_en, dma_tx_en, found, vec_ack, force_hit;
  logic [IW-1:0]     vec_idx;
  logic [DW-1:0]     vec_code;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;
  assign pend = status & mask;

  always_comb begin
    found   = 1'b0;
    vec_idx = '0;
    for (int i = STAT_W - 1; i >= 0; i--)
      if (pend[i]) begin
        found   = 1'b1;
        vec_idx = IW'(i);
      end
  end

  assign vec_code  = found ? DW'(vec_idx) + DW'(1) : '0;
  assign vec_ack   = !NEW_REV && rd_en && (addr == A_VEC) && found;
  assign clr_vec   = vec_ack ? (STAT_W'(1) << vec_idx) : '0;
  assign clr_w1c   = (NEW_REV && wr_en && addr == A_STAT) ? (wdata[STAT_W-1:0] & W1C_KEEP) : '0;
  assign force_hit = NEW_REV && wr_en && (addr == A_TEST) && wdata[TEST_FORCE];
  assign force_set = force_hit ? FORCE_SET : '0;
  assign status_nx = (status & ~clr_vec & ~clr_w1c) | evt_set | force_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= '0;
      mask      <= '0;
      dma_rx_en <= 1'b0;
      dma_tx_en <= 1'b0;
      irq       <= 1'b0;
      drq_rx    <= 1'b0;
      drq_tx    <= 1'b0;
    end else begin
      status <= status_nx;
      if (wr_en && addr == A_MASK)
        mask <= wdata[STAT_W-1:0] & MASK_KEEP;
      else if (wr_en && addr == A_DMA) begin
        if (wdata[DMA_RX_EN]) mask[RX_BIT] <= 1'b0;
        if (wdata[DMA_TX_EN]) mask[TX_BIT] <= 1'b0;
      end
      if (wr_en && addr == A_DMA) begin
        dma_rx_en <= wdata[DMA_RX_EN];
        dma_tx_en <= wdata[DMA_TX_EN];
      end
      irq    <= |pend;
      drq_rx <= dma_rx_en & status[RX_BIT];
      drq_tx <= dma_tx_en & status[TX_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_MASK: rdata = DW'(mask);
      A_STAT: rdata = DW'(status);
      A_VEC:  rdata = NEW_REV ? '0 : vec_code;
      A_DMA: begin
        rdata[DMA_RX_EN] = dma_rx_en;
        rdata[DMA_TX_EN] = dma_tx_en;
      end
      default: rdata = '0;
    endcase
  end

  assert_irq_needs_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mask != '0));

  assert_vector_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && !evt_set[vec_idx]) |=> !status[$past(vec_idx)]);

  assert_drq_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(dma_rx_en) |-> !drq_rx) and (!$past(dma_tx_en) |-> !drq_tx));

  assert_dma_drops_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DMA && wdata[DMA_RX_EN]) |=> !mask[RX_BIT]);

  assert_only_sources_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(force_hit) |-> ((status & ~$past(status) & ~$past(evt_set)) == '0));
endmodule

// File: tb/test_irq_vector_dma.sv
module test_irq_vector_dma;
  localparam int CLK_PERIOD = 10;
  localparam int N = 13;

  logic clk = 0, rst_n = 0;
  logic sel = 0, wr = 0, rd = 0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [5:0] evt = '0;
  logic [15:0] rdata_o, rdata_n;
  logic irq_o, drq_rx_o, drq_tx_o, irq_n, drq_rx_n, drq_tx_n;
  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_dma #(.NEW_REV(1'b0)) i_irq_vector_dma (
    .clk(clk), .rst_n(rst_n), .evt_set(sel ? 6'd0 : evt), .wr_en(wr & !sel), .rd_en(rd & !sel),
    .addr(addr), .wdata(wdata), .rdata(rdata_o), .irq(irq_o), .drq_rx(drq_rx_o), .drq_tx(drq_tx_o));

  irq_vector_dma #(.NEW_REV(1'b1)) i_irq_vector_dma_new (
    .clk(clk), .rst_n(rst_n), .evt_set(sel ? evt : 6'd0), .wr_en(wr & sel), .rd_en(rd & sel),
    .addr(addr), .wdata(wdata), .rdata(rdata_n), .irq(irq_n), .drq_rx(drq_rx_n), .drq_tx(drq_tx_n));

  // row: op(2) addr(3) data(16) evt(6) expected(16); op 1 write, 2 read-check, 0 event only
  localparam logic [42:0] TBL [N] = '{
    {2'd1, 3'd0, 16'hffff, 6'h00, 16'h0000},  // R5 mask write
    {2'd2, 3'd0, 16'h0000, 6'h00, 16'h001f},  // R5 five bits kept
    {2'd0, 3'd0, 16'h0000, 6'h26, 16'h0000},  // events 1,2,5
    {2'd2, 3'd1, 16'h0000, 6'h00, 16'h0026},  // R2 status
    {2'd2, 3'd2, 16'h0000, 6'h00, 16'h0002},  // R2 lowest = bit1
    {2'd2, 3'd2, 16'h0000, 6'h00, 16'h0003},  // R2 next = bit2
    {2'd2, 3'd2, 16'h0000, 6'h00, 16'h0000},  // R2 bit5 masked
    {2'd2, 3'd1, 16'h0000, 6'h00, 16'h0020},  // R2 cleared bits
    {2'd1, 3'd1, 16'h0020, 6'h00, 16'h0000},  // R6 old-rev status write
    {2'd2, 3'd1, 16'h0000, 6'h00, 16'h0020},  // R6 ignored
    {2'd1, 3'd3, 16'hffff, 6'h00, 16'h0000},  // R4 dma write
    {2'd2, 3'd3, 16'h0000, 6'h00, 16'h8080},  // R4 two bits kept
    {2'd2, 3'd0, 16'h0000, 6'h00, 16'h0007}   // R4 mask bits 3,4 dropped
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wreg(bit s, logic [2:0] a, logic [15:0] d, logic [5:0] e = '0);
    @(negedge clk); sel = s; wr = 1; addr = a; wdata = d; evt = e;
    @(posedge clk); #1 wr = 0; evt = '0;
  endtask

  task automatic rreg(bit s, logic [2:0] a, logic [15:0] exp, string req, logic [5:0] e = '0);
    @(negedge clk); sel = s; rd = 1; addr = a; evt = e;
    #(CLK_PERIOD/4) chk(req, s ? rdata_n : rdata_o, exp);
    @(posedge clk); #1 rd = 0; evt = '0;
  endtask

  task automatic pulse(bit s, logic [5:0] e);
    @(negedge clk); sel = s; evt = e;
    @(posedge clk); #1 evt = '0;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9 reset state
    rreg(0, 3'd0, 16'h0, "R9 mask");
    rreg(0, 3'd1, 16'h0, "R9 status");
    rreg(0, 3'd3, 16'h0, "R9 dma");
    chk("R9 lines", {13'd0, irq_o, drq_rx_o, drq_tx_o}, 16'h0);

    for (int k = 0; k < N; k++) begin
      case (TBL[k][42:41])
        2'd1: wreg(0, TBL[k][40:38], TBL[k][37:22]);
        2'd2: rreg(0, TBL[k][40:38], TBL[k][15:0], $sformatf("R2/R4/R5/R6 row %0d", k));
        default: pulse(0, TBL[k][21:16]);
      endcase
    end

    // status 0x20, mask 0x07: nothing pending
    settle();
    chk("R1 idle low", {15'd0, irq_o}, 16'h0);
    pulse(0, 6'h01);
    settle();
    chk("R1 raised", {15'd0, irq_o}, 16'h1);
    // R8 vector clears bit0 while event sets bit2
    rreg(0, 3'd2, 16'h0001, "R8 vector code", 6'h04);
    rreg(0, 3'd1, 16'h0024, "R8 both applied");
    // R8 same bit: event wins
    rreg(0, 3'd2, 16'h0003, "R8 vector code same bit", 6'h04);
    rreg(0, 3'd1, 16'h0024, "R8 event wins");
    // R3 DMA requests (rx enabled, tx enabled from table)
    wreg(0, 3'd3, 16'h8000);
    pulse(0, 6'h18);
    settle();
    chk("R3 rx follows", {15'd0, drq_rx_o}, 16'h1);
    chk("R3 tx gated", {15'd0, drq_tx_o}, 16'h0);
    wreg(0, 3'd3, 16'h0080);
    settle();
    chk("R3 rx off", {15'd0, drq_rx_o}, 16'h0);
    chk("R3 tx follows", {15'd0, drq_tx_o}, 16'h1);
    // R7 old rev ignores self-test
    wreg(0, 3'd4, 16'h0800);
    rreg(0, 3'd1, 16'h003c, "R7 old rev ignored");

    // new revision
    wreg(1, 3'd0, 16'hffff);
    rreg(1, 3'd0, 16'h003f, "R5 six bits");
    wreg(1, 3'd4, 16'h0800);
    rreg(1, 3'd1, 16'h003f, "R7 forced");
    settle();
    chk("R1 new rev irq", {15'd0, irq_n}, 16'h1);
    rreg(1, 3'd2, 16'h0000, "R6 vector reads 0");
    rreg(1, 3'd1, 16'h003f, "R6 vector no effect");
    wreg(1, 3'd1, 16'hffff);
    rreg(1, 3'd1, 16'h0018, "R6 w1c limited");
    wreg(1, 3'd1, 16'h0001, 6'h01);
    rreg(1, 3'd1, 16'h0019, "R8 event beats clear");
    wreg(1, 3'd1, 16'h0001, 6'h02);
    rreg(1, 3'd1, 16'h001a, "R8 clear and set");
    wreg(1, 3'd0, 16'h0000);
    settle(); settle();
    chk("R1 lowered", {15'd0, irq_n}, 16'h0);

    finish_run();
  end
endmodule